// File: doc/BRIEF.md
# Low-Rate Watchdog with Sleep Wake

This block guards a processor against runaway software. A counter, clocked from its own slow clock `wd_clk`, advances while the watchdog is enabled. If software does not restart it in time, the counter overflows. The overflow raises a reset request when the system is awake, or a wake request when the system is asleep. The counter does not depend on the system clock, so it keeps counting when the main clock has stopped.

Two sources can enable the block. The build-time enable `cfg_en` is captured while the watchdog domain is in reset. When captured high, it forces the watchdog on. When captured low, the software enable `sw_en` decides. Software restarts the count with a one-cycle `kick` strobe in the system domain. The kick, the sleep level and the software enable cross into the watchdog domain. The two timeout events cross back as one-cycle pulses in the system domain. An active-low status bit records that the last timeout woke the system.

Top module: `lrwd_top`

## Requirements
- R1: `cfg_en` is captured while `wd_rst_n` is low. If it was captured as 1, the watchdog runs whatever `sw_en` is. Changes of `cfg_en` after reset release have no effect until the next reset.
- R2: If `cfg_en` was captured as 0, the watchdog runs only while `sw_en` is 1. While it is disabled the count is held at zero, so a re-enable starts a full period.
- R3: A timeout comes 2^(PRE_W+CNT_W) `wd_clk` cycles after the count starts from zero, and never earlier. With the bench values PRE_W=2 and CNT_W=3, this is 32 cycles.
- R4: A timeout while `sleep` is 0 gives a `rst_req` pulse exactly one `sys_clk` cycle wide.
- R5: A timeout while `sleep` is 1 gives a one-cycle `wake_req` pulse and no `rst_req`. The two requests are never high together.
- R6: A `kick` pulse restarts the count from zero. Kicks spaced closer than one period prevent every timeout. Kicks must be at least 3 `wd_clk` cycles apart.
- R7: `wake_stat_n` is 1 after reset. It goes to 0 in the cycle after `wake_req` and returns to 1 after a `kick`. If both happen in the same cycle, the clear wins.
- R8: The count advances with `sys_clk` stopped. A sleep timeout that occurs while `sys_clk` is stopped is delivered as one `wake_req` once `sys_clk` runs again.
- R9: During and right after reset, `rst_req` and `wake_req` are 0 and `wake_stat_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; may stop during sleep |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| wd_clk | input | 1 | Free-running low-rate watchdog clock |
| wd_rst_n | input | 1 | Synchronous active-low reset, watchdog domain |
| cfg_en | input | 1 | Build-time enable, captured during watchdog reset |
| sw_en | input | 1 | Software enable, used when `cfg_en` was captured low |
| kick | input | 1 | One-cycle restart strobe, system domain |
| sleep | input | 1 | System is sleeping |
| rst_req | output | 1 | One-cycle reset request, system domain |
| wake_req | output | 1 | One-cycle wake request, system domain |
| wake_stat_n | output | 1 | 0 when the last timeout was a sleep wake |

## Verification
The hardest case to reach is a sleep timeout that matures while the system clock is frozen. The event must wait in the crossing and appear exactly once when the clock returns. The bench gates its own `sys_clk` off after arming a sleeping watchdog and holds it off past a full period. It then checks that nothing came out while the clock was stopped and that exactly one wake pulse follows the restart. A second hard case is the count held at zero while disabled. The bench turns the software enable off part-way through a period, turns it back on and checks that no event arrives before a full period has elapsed.

// File: rtl/lrwd_pkg.sv
// Shared types for the low-rate watchdog.
package lrwd_pkg;
    // Kind of timeout the counter produced in a given watchdog cycle.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_RESET = 2'd1,
        EV_WAKE  = 2'd2
    } wd_event_e;
endpackage

// File: rtl/lrwd_sync.sv
// Multi-stage synchronizer for slowly changing levels.
// Assumes each bit is independent; no coherency between bits is implied.
module lrwd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lrwd_pulse_xfer.sv
// Carries single-cycle pulses between clock domains by toggling a level.
// Assumes source pulses are spaced at least three destination cycles apart.
// A toggle survives a stopped destination clock and is seen on its return.
module lrwd_pulse_xfer (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tgl_q;
    logic tgl_s;
    logic tgl_prev;

    // Flip the transfer level once per source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tgl_q <= 1'b0;
        else if (src_pulse) tgl_q <= ~tgl_q;
    end

    lrwd_sync #(.W(1), .STAGES(2)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (tgl_q),
        .q     (tgl_s)
    );

    // Turn each change of the synchronized level into a one-cycle pulse.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            tgl_prev  <= 1'b0;
            dst_pulse <= 1'b0;
        end else begin
            tgl_prev  <= tgl_s;
            dst_pulse <= tgl_s ^ tgl_prev;
        end
    end
endmodule

// File: rtl/lrwd_core.sv
// Watchdog-domain counter: enable choice, prescaler, main count, timeout decode.
// Assumes all inputs except cfg_en are already synchronous to clk.
// cfg_en is captured only while rst_n is low.
module lrwd_core
    import lrwd_pkg::*;
#(
    parameter int PRE_W = 4,
    parameter int CNT_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en,
    input  logic      sw_en_s,
    input  logic      sleep_s,
    input  logic      kick_p,
    output wd_event_e evt
);
    logic             cfg_q;
    logic             run;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;
    logic             last;

    // Hold the build-time enable as it stood at reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_en;
    end

    assign run  = cfg_q | sw_en_s;
    assign last = (&pre) & (&cnt);

    // Prescaler: free-running while enabled, cleared by a kick or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick_p) pre <= '0;
        else pre <= pre + 1'b1;
    end

    // Main count: steps on prescaler wrap, cleared like the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick_p) cnt <= '0;
        else if (&pre) cnt <= cnt + 1'b1;
    end

    // Decode the overflow into a reset or wake event by the sleep state.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= EV_NONE;
        else if (run && !kick_p && last) evt <= sleep_s ? EV_WAKE : EV_RESET;
        else evt <= EV_NONE;
    end

    // R1: the captured enable never moves outside reset.
    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

    // R2: a disabled watchdog leaves the count at zero.
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre == '0 && cnt == '0));

    // R6: a kick restarts the count from zero.
    p_kick_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_p |=> (pre == '0 && cnt == '0));

    // R5: a reset event never comes from a sleeping system.
    p_sleep_no_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_RESET) |-> !$past(sleep_s));
endmodule

// File: rtl/lrwd_top.sv
// Low-rate watchdog with sleep wake: wires the counter and the crossings.
// Assumes kicks are spaced at least three wd_clk cycles apart and that
// wd_clk is slower than sys_clk while both run.
module lrwd_top
    import lrwd_pkg::*;
#(
    parameter int PRE_W = 4,
    parameter int CNT_W = 8
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic wd_clk,
    input  logic wd_rst_n,
    input  logic cfg_en,
    input  logic sw_en,
    input  logic kick,
    input  logic sleep,
    output logic rst_req,
    output logic wake_req,
    output logic wake_stat_n
);
    logic      kick_wd;
    logic      sw_en_s;
    logic      sleep_s;
    wd_event_e evt;

    lrwd_pulse_xfer u_kick_xfer (
        .src_clk   (sys_clk),
        .src_rst_n (sys_rst_n),
        .src_pulse (kick),
        .dst_clk   (wd_clk),
        .dst_rst_n (wd_rst_n),
        .dst_pulse (kick_wd)
    );

    lrwd_sync #(.W(2), .STAGES(2)) u_lvl_sync (
        .clk   (wd_clk),
        .rst_n (wd_rst_n),
        .d     ({sleep, sw_en}),
        .q     ({sleep_s, sw_en_s})
    );

    lrwd_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
        .clk     (wd_clk),
        .rst_n   (wd_rst_n),
        .cfg_en  (cfg_en),
        .sw_en_s (sw_en_s),
        .sleep_s (sleep_s),
        .kick_p  (kick_wd),
        .evt     (evt)
    );

    lrwd_pulse_xfer u_rst_xfer (
        .src_clk   (wd_clk),
        .src_rst_n (wd_rst_n),
        .src_pulse (evt == EV_RESET),
        .dst_clk   (sys_clk),
        .dst_rst_n (sys_rst_n),
        .dst_pulse (rst_req)
    );

    lrwd_pulse_xfer u_wake_xfer (
        .src_clk   (wd_clk),
        .src_rst_n (wd_rst_n),
        .src_pulse (evt == EV_WAKE),
        .dst_clk   (sys_clk),
        .dst_rst_n (sys_rst_n),
        .dst_pulse (wake_req)
    );

    // Wake status: cleared by a wake request, set again by a kick.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) wake_stat_n <= 1'b1;
        else if (wake_req) wake_stat_n <= 1'b0;
        else if (kick) wake_stat_n <= 1'b1;
    end

    // R4: a reset request lasts one system cycle.
    p_rst_one_cycle_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rst_req |=> !rst_req);

    // R5: a wake request lasts one system cycle and never pairs with a reset.
    p_wake_one_cycle_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        wake_req |=> !wake_req);
    p_no_both_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !(rst_req && wake_req));

    // R7: the status reads low right after a wake request.
    p_stat_clear_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        wake_req |=> !wake_stat_n);
endmodule

// File: tb/lrwd_top_bench.sv
module lrwd_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_HALF    = 17;
    localparam int PRE_W      = 2;
    localparam int CNT_W      = 3;
    localparam int TO         = 1 << (PRE_W + CNT_W);

    logic sys_clk = 1'b0;
    logic wd_clk  = 1'b0;
    logic sys_run = 1'b1;
    logic sys_rst_n, wd_rst_n, cfg_en, sw_en, kick, sleep;
    logic rst_req, wake_req, wake_stat_n;

    int n_chk = 0, n_fail = 0;
    int rst_cnt = 0, wake_cnt = 0, wide = 0;
    int rb = 0, wb = 0;
    logic prev_r = 1'b0, prev_w = 1'b0;
    bit done = 1'b0;

    lrwd_top #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_lrwd_top (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
        .cfg_en(cfg_en), .sw_en(sw_en), .kick(kick), .sleep(sleep),
        .rst_req(rst_req), .wake_req(wake_req), .wake_stat_n(wake_stat_n)
    );

    initial forever begin
        #(CLK_PERIOD/2);
        if (sys_run) sys_clk = ~sys_clk;
    end
    initial forever #(WD_HALF) wd_clk = ~wd_clk;

    // Count request pulses and any pulse longer than one cycle.
    always @(negedge sys_clk) begin
        if (sys_rst_n) begin
            if (rst_req) rst_cnt++;
            if (wake_req) wake_cnt++;
            if ((rst_req && prev_r) || (wake_req && prev_w)) wide++;
        end
        prev_r = rst_req;
        prev_w = wake_req;
    end

    // Expected number of timeouts when gap wd cycles follow one kick.
    function automatic int exp_events(input int gap);
        return (gap < TO - 6) ? 0 : ((gap < 2 * TO) ? 1 : 2);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wd_wait(input int n);
        repeat (n) @(posedge wd_clk);
    endtask

    task automatic do_kick();
        @(negedge sys_clk) kick = 1'b1;
        @(negedge sys_clk) kick = 1'b0;
    endtask

    task automatic mark();
        rb = rst_cnt;
        wb = wake_cnt;
    endtask

    task automatic do_reset(input logic cfg);
        @(negedge sys_clk);
        cfg_en = cfg; sw_en = 0; sleep = 0; kick = 0;
        sys_rst_n = 0; wd_rst_n = 0;
        wd_wait(4);
        @(negedge sys_clk);
        sys_rst_n = 1; wd_rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        sys_rst_n = 0; wd_rst_n = 0; cfg_en = 1; sw_en = 0; kick = 0; sleep = 0;
        do_reset(1'b1);
        @(negedge sys_clk);
        // R9: idle values after reset
        chk("R9 rst_req", rst_req, 0);
        chk("R9 wake_req", wake_req, 0);
        chk("R9 wake_stat_n", wake_stat_n, 1);

        // R6: random kick spacing below the period prevents timeouts
        mark();
        for (int i = 0; i < 12; i++) begin
            int gap;
            gap = $urandom_range(4, 20);
            do_kick();
            wd_wait(gap);
            chk("R6 kicked no reset", rst_cnt - rb, exp_events(gap));
            mark();
        end
        // R3: nothing early; R4: one reset after a full period
        do_kick();
        wd_wait(24);
        chk("R3 early", rst_cnt - rb, 0);
        wd_wait(20);
        chk("R4 reset count", rst_cnt - rb, exp_events(44));
        chk("R4 pulse width", wide, 0);

        // R1: late change of cfg_en and sw_en low do not stop it
        @(negedge sys_clk) cfg_en = 0;
        mark();
        do_kick();
        wd_wait(44);
        chk("R1 still enabled", rst_cnt - rb, 1);

        // R5/R7: sleep timeout wakes instead of resetting
        @(negedge sys_clk) sleep = 1;
        mark();
        do_kick();
        wd_wait(44);
        chk("R5 wake count", wake_cnt - wb, 1);
        chk("R5 no reset", rst_cnt - rb, 0);
        chk("R7 stat cleared", wake_stat_n, 0);
        @(negedge sys_clk) sleep = 0;
        do_kick();
        @(negedge sys_clk);
        chk("R7 stat set by kick", wake_stat_n, 1);

        // R8: sleep timeout while the system clock is stopped
        @(negedge sys_clk) sleep = 1;
        do_kick();
        mark();
        wd_wait(4);
        sys_run = 0;
        wd_wait(50);
        chk("R8 nothing while stopped", wake_cnt - wb, 0);
        sys_run = 1;
        repeat (10) @(negedge sys_clk);
        chk("R8 wake on resume", wake_cnt - wb, 1);
        chk("R8 no reset", rst_cnt - rb, 0);
        @(negedge sys_clk) sleep = 0;

        // R4/R5: random sleep state per timeout
        for (int i = 0; i < 6; i++) begin
            logic s;
            s = 1'($urandom_range(0, 1));
            @(negedge sys_clk) sleep = s;
            mark();
            do_kick();
            wd_wait(44);
            chk("R5 random wake", wake_cnt - wb, s ? 1 : 0);
            chk("R4 random reset", rst_cnt - rb, s ? 0 : 1);
        end
        @(negedge sys_clk) sleep = 0;

        // R2: software enable path with hold at zero
        do_reset(1'b0);
        mark();
        wd_wait(80);
        chk("R2 disabled no reset", rst_cnt - rb, 0);
        @(negedge sys_clk) sw_en = 1;
        wd_wait(20);
        chk("R2 early after enable", rst_cnt - rb, 0);
        wd_wait(24);
        chk("R2 enabled reset", rst_cnt - rb, 1);
        @(negedge sys_clk) sw_en = 0;
        wd_wait(20);
        mark();
        @(negedge sys_clk) sw_en = 1;
        wd_wait(26);
        chk("R2 held count full period", rst_cnt - rb, 0);
        wd_wait(18);
        chk("R2 reset after re-enable", rst_cnt - rb, 1);
        chk("R4 pulse width end", wide, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule